// File: doc/BRIEF.md
# Join Wrapper with Bypassable Input Slots

This block sits between a set of upstream relay stations and a core whose clock is gated. Each of the N input channels carries a valid flag and a data word. The block gathers one word from every channel and then lets the core advance for one cycle. A channel whose word comes early is parked in a one-word slot. While it is parked, the channel holds its upstream peer back with a stop flag. A downstream stop input blocks the core from advancing. While that stop is high, any arriving word is parked.

Each slot is a register with a mux in front of it. When the slot is empty, the live wire goes straight through to the core. When the slot is occupied, the stored word goes to the core. On the cycle the core is enabled, the block raises its output valid, and the data bus shows the word chosen for each channel.

Back-pressure follows these rules:
- The handshake is valid/stop. Here stop is the inverse of ready.
- A channel's stop depends on the same cycle's inputs, so it is a Mealy output.
- Upstream must not present a word on a cycle when that channel's stop is high.
- A word presented while stop is low is always accepted. It is either consumed at once or parked.

Top module: `lis_shell_wrap`

## Requirements
- R1: While reset is held, and after it with no input valid: core_en, out_valid and every up_stop bit are 0, and no slot holds a word.
- R2: core_en is 1 in a cycle exactly when every channel is present and stop_dn is 0. A channel is present when its in_valid is 1 or its slot is occupied.
- R3: out_valid equals core_en in the same cycle. Channel i's word occupies out_data bits [i*W +: W], and the same layout is used on in_data.
- R4: A word that arrives on a cycle the core does not fire is stored in its empty slot. It stays there unchanged until a later firing cycle consumes it.
- R5: For an empty slot, out_data shows the live in_data slice. For an occupied slot, out_data shows the stored word, whatever is on the wire.
- R6: up_stop[i] is 1 exactly when slot i is occupied and either stop_dn is 1 or some channel is not present. Upstream must not assert in_valid[i] while up_stop[i] is 1.
- R7: An occupied slot empties after a firing cycle. If a new word arrives on that firing cycle, that word replaces the stored one and the slot stays occupied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | N_CH | Per-channel word-present flag |
| in_data | input | N_CH*W | Per-channel words, channel i at [i*W +: W] |
| up_stop | output | N_CH | Per-channel back-pressure toward upstream |
| stop_dn | input | 1 | Back-pressure from downstream |
| core_en | output | 1 | Core clock enable for this cycle |
| out_valid | output | 1 | Output words valid this cycle |
| out_data | output | N_CH*W | Word chosen per channel for the core |

## Verification
core_en, out_valid, up_stop and out_data all settle in the same cycle as the inputs that cause them, with no register in the path. The bench therefore samples them 1 ns after driving inputs, still inside that cycle. A captured or cleared slot shows its effect only in the next cycle, so a parked word is checked one clock after its arrival and at every cycle until it is consumed. The scoreboard monitor compares firing words at the falling edge of the same cycle the driver queued them. This keeps every comparison between the drive point and the next rising edge.

// File: rtl/lis_shell_pkg.sv
package lis_shell_pkg;
  typedef enum logic {
    SLOT_EMPTY = 1'b0,
    SLOT_HELD  = 1'b1
  } slot_state_e;
endpackage

// File: rtl/lis_join_ctrl.sv
module lis_join_ctrl #(
  parameter int N_CH = 4
) (
  input  logic [N_CH-1:0] present,
  input  logic            stop_dn,
  output logic            fire,
  output logic            any_missing
);
  always_comb begin
    any_missing = ~(&present);
    fire        = ~any_missing & ~stop_dn;
  end
endmodule

// File: rtl/lis_bypass_slot.sv
module lis_bypass_slot
  import lis_shell_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  input  logic         fire,
  input  logic         any_missing,
  input  logic         stop_dn,
  output logic         present,
  output logic [W-1:0] word_out,
  output logic         stop_up
);
  slot_state_e  state_q;
  logic [W-1:0] store_q;
  logic         held;
  logic         load;

  assign held = (state_q == SLOT_HELD);

  // Park when not consumed now; refill a held slot only as it drains.
  always_comb begin
    if (held) load = in_valid & fire;
    else      load = in_valid & ~fire;
    present  = in_valid | held;
    word_out = held ? store_q : in_data;
    stop_up  = held & (stop_dn | any_missing);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SLOT_EMPTY;
      store_q <= '0;
    end else if (load) begin
      state_q <= SLOT_HELD;
      store_q <= in_data;
    end else if (fire) begin
      state_q <= SLOT_EMPTY;
    end
  end

  // R6: upstream respects stop
  a_r6_no_word_under_stop: assert property (@(posedge clk) disable iff (!rst_n)
    stop_up |-> !in_valid);
  // R4: a parked word waits unchanged
  a_r4_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (held && !fire) |=> (held && $stable(store_q)));
  // R7: drained slot empties
  a_r7_clear_on_fire: assert property (@(posedge clk) disable iff (!rst_n)
    (held && fire && !in_valid) |=> !held);
endmodule

// File: rtl/lis_shell_wrap.sv
module lis_shell_wrap #(
  parameter int N_CH = 4,
  parameter int W    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_CH-1:0]   in_valid,
  input  logic [N_CH*W-1:0] in_data,
  output logic [N_CH-1:0]   up_stop,
  input  logic              stop_dn,
  output logic              core_en,
  output logic              out_valid,
  output logic [N_CH*W-1:0] out_data
);
  localparam int BUS_W = N_CH * W;

  logic [N_CH-1:0]  present;
  logic [BUS_W-1:0] word_bus;
  logic             fire;
  logic             any_missing;

  lis_join_ctrl #(.N_CH(N_CH)) u_join (
    .present     (present),
    .stop_dn     (stop_dn),
    .fire        (fire),
    .any_missing (any_missing)
  );

  for (genvar i = 0; i < N_CH; i++) begin : g_slot
    lis_bypass_slot #(.W(W)) u_slot (
      .clk         (clk),
      .rst_n       (rst_n),
      .in_valid    (in_valid[i]),
      .in_data     (in_data[i*W +: W]),
      .fire        (fire),
      .any_missing (any_missing),
      .stop_dn     (stop_dn),
      .present     (present[i]),
      .word_out    (word_bus[i*W +: W]),
      .stop_up     (up_stop[i])
    );
  end

  assign core_en   = fire;
  assign out_valid = fire;
  assign out_data  = word_bus;

  // R2: no firing into a stalled downstream
  a_r2_fire_needs_dn_free: assert property (@(posedge clk) disable iff (!rst_n)
    core_en |-> !stop_dn);
  // R6: stop toward any channel excludes firing
  a_r6_stop_blocks_fire: assert property (@(posedge clk) disable iff (!rst_n)
    (|up_stop) |-> !core_en);
endmodule

// File: tb/sim_lis_shell_wrap.sv
module sim_lis_shell_wrap;
  localparam int N = 3;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [N-1:0]   in_valid = '0;
  logic [N*W-1:0] in_data = '0;
  logic           stop_dn = 1'b0;
  logic [N-1:0]   up_stop;
  logic           core_en, out_valid;
  logic [N*W-1:0] out_data;

  lis_shell_wrap #(.N_CH(N), .W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .up_stop(up_stop), .stop_dn(stop_dn), .core_en(core_en),
    .out_valid(out_valid), .out_data(out_data)
  );

  int n_chk = 0;
  int n_err = 0;
  logic [N*W-1:0] exp_q[$];
  logic [N-1:0]   held_m = '0;
  logic [W-1:0]   word_m [N];

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // Driver: one cycle of stimulus, same-cycle checks, model update.
  task automatic step(input logic [N-1:0] v, input logic [N*W-1:0] d, input logic sdn);
    logic [N-1:0]   pres, exps;
    logic [N*W-1:0] expd;
    logic           all_p, fire;
    @(posedge clk); #1;
    in_valid = v; in_data = d; stop_dn = sdn;
    pres  = held_m | v;
    all_p = &pres;
    fire  = all_p & ~sdn;
    for (int i = 0; i < N; i++) begin
      expd[i*W +: W] = held_m[i] ? word_m[i] : d[i*W +: W];
      exps[i] = held_m[i] & (sdn | ~all_p);
    end
    if (fire) exp_q.push_back(expd);
    #1;
    chk(core_en == fire, "R2 core_en", 64'(core_en), 64'(fire));
    chk(out_valid == fire, "R3 out_valid", 64'(out_valid), 64'(fire));
    chk(up_stop == exps, "R6 up_stop", 64'(up_stop), 64'(exps));
    chk(out_data == expd, "R5 mux select", 64'(out_data), 64'(expd));
    for (int i = 0; i < N; i++) begin
      if (v[i] && (held_m[i] ? fire : !fire)) begin
        held_m[i] = 1'b1;
        word_m[i] = d[i*W +: W];
      end else if (fire) begin
        held_m[i] = 1'b0;
      end
    end
  endtask

  // Monitor: scoreboard of firing words (R3 layout, R4/R7 contents).
  always @(negedge clk) begin
    if (rst_n && core_en) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R3 unexpected fire", 64'(out_data), 64'(0));
      end else begin
        logic [N*W-1:0] e;
        e = exp_q.pop_front();
        chk(out_data == e, "R4 R7 fired words", 64'(out_data), 64'(e));
      end
    end
  end

  initial begin
    #(4 * 200000);
    chk(1'b0, "watchdog", 64'(0), 64'(1));
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [15:0] lf;
    #9;
    chk(core_en == 1'b0, "R1 reset core_en", 64'(core_en), 64'(0));
    chk(up_stop == '0, "R1 reset up_stop", 64'(up_stop), 64'(0));
    chk(out_valid == 1'b0, "R1 reset out_valid", 64'(out_valid), 64'(0));
    @(negedge clk); rst_n = 1'b1;
    // R1: slots empty after reset, wire passes through
    step(3'b000, 24'hA1B2C3, 1'b0);
    // R2 all arrive together
    step(3'b111, 24'h332211, 1'b0);
    // R4 early word parked, R5 stored word replayed over garbage wire
    step(3'b001, 24'h0000_44, 1'b0);
    step(3'b110, 24'h6655EE, 1'b0);
    // R6 downstream stop parks everything, then stops all upstream
    step(3'b111, 24'h998877, 1'b1);
    step(3'b000, 24'hFFFFFF, 1'b1);
    // R7 release: fire from slots while ch1 refills
    step(3'b010, 24'h00AA00, 1'b0);
    step(3'b101, 24'hCC00BB, 1'b0);
    // R6 staggered arrival with a missing channel
    step(3'b100, 24'h110000, 1'b0);
    step(3'b001, 24'h000022, 1'b0);
    step(3'b010, 24'h003300, 1'b0);
    // pseudo-random traffic
    lf = 16'hACE1;
    for (int k = 0; k < 400; k++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      step(lf[2:0] & ~held_m, {lf[7:0], lf[15:8], lf[11:4]}, lf[5] & lf[9]);
    end
    step(3'b000, 24'h0, 1'b0);
    @(posedge clk); #1;
    chk(exp_q.size() == 0, "R2 scoreboard drained", 64'(exp_q.size()), 64'(0));
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule